// File: doc/BRIEF.md
# Clear-Only Status Store with Page Protection

This block holds the non-volatile bookkeeping for a 64-page, 32-byte-per-page byte store, and the store itself. Every cell starts erased at 0xFF. Programming can only pull bits from 1 to 0. A sparse status space holds three 64-bit maps and one redirection byte per page:

- a page-lock map, which freezes data pages;
- a redirect-lock map, which freezes redirection bytes;
- a page-used map, which is informational only.

A redirection byte of 0xFF means the page is current. Any other value names the replacement page as the bitwise complement of that value.

A program request is captured into a one-entry staging register. It is committed at the next clock edge only if the program-enable input is high then and the target is not locked. The program-enable input models the programming-voltage detector. A request that is refused raises a single-cycle reject flag.

Reads are combinational from the selected space. A side port translates any page number into its redirection verdict.

Top module: `apnd_store`

## Requirements
- R1: After reset every data byte and every implemented status byte reads 0xFF, `progReject` is 0 and every page looks up as valid.
- R2: A committed program leaves the addressed byte equal to its previous value AND `progData`, so no bit ever changes from 0 to 1.
- R3: A request sampled with `progReq`=1 at one rising edge commits at the following edge only if `progEn` is 1 during the cycle before that edge. The new value is readable from the cycle after the commit edge.
- R4: A staged request that meets `progEn`=0 at its commit edge leaves memory unchanged. `progReject` is then 1 for exactly the cycle after that edge.
- R5: Page p of the data space (`addr[10:5]` when `space`=0) is locked when bit p%8 of status byte 0x000+p/8 is 0. A program to a locked page is refused with `progReject`, and the page stays readable.
- R6: Redirection byte 0x100+p is locked when bit p%8 of status byte 0x020+p/8 is 0. A program to a locked redirection byte is refused with `progReject`.
- R7: Status bytes 0x040–0x047 can be programmed but have no effect on any permission.
- R8: Status addresses outside 0x000–0x007, 0x020–0x027, 0x040–0x047 and 0x100–0x13F read 0xFF. Enabled programs to them change nothing and raise no reject.
- R9: For `lookPage`=p, `lookValid` is 1 exactly when byte 0x100+p is 0xFF, and `lookTarget` equals the low 6 bits of that byte's complement.
- R10: A lock committed at one edge already refuses a request to the locked target that commits at the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| space | input | 1 | 0 selects the data store, 1 the status space (read and program) |
| addr | input | 11 | Byte address for read and program request |
| rdData | output | 8 | Byte at `addr` in `space` (combinational) |
| progReq | input | 1 | Program request, captured with `addr`, `space`, `progData` |
| progData | input | 8 | Byte to AND into the target |
| progEn | input | 1 | Programming permitted in this cycle |
| progReject | output | 1 | One-cycle flag for a refused commit |
| lookPage | input | 6 | Page to translate |
| lookValid | output | 1 | Page is current (redirection byte is 0xFF) |
| lookTarget | output | 6 | Replacement page number |

## Verification
Two things can fall on one edge: a lock byte being committed, and a new request to the page it guards being staged. That request commits on the following edge. This is provoked by issuing the lock request and the guarded request on consecutive cycles with `progEn` held high. It is judged by whether the second commit is refused and the target byte keeps its value.

A read of an address in the same cycle its program commits is also compared every cycle. The old value must be shown until the edge, and the new value after it. A behavioural model with a queue of staged requests predicts `rdData`, `progReject` and the lookup outputs on every clock. Random enables and addresses then mix these collisions further.

// File: rtl/apnd_pkg.sv
`timescale 1ns/1ps
package apnd_pkg;
  localparam int ADDR_W     = 11;
  localparam int PAGES      = 64;
  localparam int PAGE_BYTES = 32;
  localparam int DATA_BYTES = PAGES * PAGE_BYTES;
  localparam int MAP_BYTES  = PAGES / 8;
  localparam int STAT_BYTES = 3 * MAP_BYTES + PAGES;
  localparam int IDX_W      = $clog2(STAT_BYTES);
  localparam int PG_W       = $clog2(PAGES);
  localparam int OFF_W      = $clog2(PAGE_BYTES);
  localparam int MAP_W      = $clog2(MAP_BYTES);

  localparam logic [ADDR_W-1:0] LOCK_BASE  = 11'h000;
  localparam logic [ADDR_W-1:0] RLOCK_BASE = 11'h020;
  localparam logic [ADDR_W-1:0] USED_BASE  = 11'h040;
  localparam logic [ADDR_W-1:0] REDIR_BASE = 11'h100;
  localparam logic [ADDR_W-1:0] MAP_SPAN   = ADDR_W'(MAP_BYTES);
  localparam logic [ADDR_W-1:0] REDIR_SPAN = ADDR_W'(PAGES);

  typedef enum logic [2:0] {RG_NONE, RG_LOCK, RG_RLOCK, RG_USED, RG_REDIR} region_e;

  typedef struct packed {
    logic              wrData;
    logic              wrStatus;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        wdata;
  } strobe_t;

  function automatic region_e regionOf(logic [ADDR_W-1:0] a);
    if (a < LOCK_BASE + MAP_SPAN) return RG_LOCK;
    if (a >= RLOCK_BASE && a < RLOCK_BASE + MAP_SPAN) return RG_RLOCK;
    if (a >= USED_BASE && a < USED_BASE + MAP_SPAN) return RG_USED;
    if (a >= REDIR_BASE && a < REDIR_BASE + REDIR_SPAN) return RG_REDIR;
    return RG_NONE;
  endfunction

  function automatic logic [IDX_W-1:0] statIdx(logic [ADDR_W-1:0] a);
    case (regionOf(a))
      RG_LOCK:  return IDX_W'(a[MAP_W-1:0]);
      RG_RLOCK: return IDX_W'(MAP_BYTES) + IDX_W'(a[MAP_W-1:0]);
      RG_USED:  return IDX_W'(2 * MAP_BYTES) + IDX_W'(a[MAP_W-1:0]);
      RG_REDIR: return IDX_W'(3 * MAP_BYTES) + IDX_W'(a[PG_W-1:0]);
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/apnd_datapath.sv
`timescale 1ns/1ps
module apnd_datapath
  import apnd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              space,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        rdData,
  output logic [PAGES-1:0]  pageOpen,
  output logic [PAGES-1:0]  redirOpen,
  input  logic [PG_W-1:0]   lookPage,
  output logic              lookValid,
  output logic [PG_W-1:0]   lookTarget
);
  localparam logic [IDX_W-1:0] REDIR_IDX = IDX_W'(3 * MAP_BYTES);

  logic [7:0] dataMem [DATA_BYTES];
  logic [7:0] statMem [STAT_BYTES];
  logic [7:0] redirByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DATA_BYTES; i++) dataMem[i] <= 8'hFF;
      for (int i = 0; i < STAT_BYTES; i++) statMem[i] <= 8'hFF;
    end else begin
      if (strb.wrData)
        dataMem[strb.addr] <= dataMem[strb.addr] & strb.wdata;
      if (strb.wrStatus)
        statMem[statIdx(strb.addr)] <= statMem[statIdx(strb.addr)] & strb.wdata;
    end
  end

  // unpack the two lock maps into one permission bit per page
  for (genvar p = 0; p < PAGES; p++) begin : g_open
    assign pageOpen[p]  = statMem[p / 8][p % 8];
    assign redirOpen[p] = statMem[MAP_BYTES + p / 8][p % 8];
  end

  always_comb begin
    if (!space) rdData = dataMem[addr];
    else if (regionOf(addr) == RG_NONE) rdData = 8'hFF;
    else rdData = statMem[statIdx(addr)];
  end

  assign redirByte  = statMem[REDIR_IDX + IDX_W'(lookPage)];
  assign lookValid  = &redirByte;
  assign lookTarget = ~redirByte[PG_W-1:0];
endmodule

// File: rtl/apnd_ctrl.sv
`timescale 1ns/1ps
module apnd_ctrl
  import apnd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              progReq,
  input  logic              space,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        progData,
  input  logic              progEn,
  input  logic [PAGES-1:0]  pageOpen,
  input  logic [PAGES-1:0]  redirOpen,
  output strobe_t           strb,
  output logic              progReject
);
  logic              stValid;
  logic              stSpace;
  logic [ADDR_W-1:0] stAddr;
  logic [7:0]        stData;
  region_e           stRegion;
  logic              allowed;
  logic              commitNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stValid    <= 1'b0;
      stSpace    <= 1'b0;
      stAddr     <= '0;
      stData     <= '0;
      progReject <= 1'b0;
    end else begin
      stValid    <= progReq;
      if (progReq) begin
        stSpace <= space;
        stAddr  <= addr;
        stData  <= progData;
      end
      progReject <= stValid && (!progEn || !allowed);
    end
  end

  always_comb begin
    stRegion = regionOf(stAddr);
    if (!stSpace)
      allowed = pageOpen[stAddr[OFF_W +: PG_W]];
    else if (stRegion == RG_REDIR)
      allowed = redirOpen[stAddr[PG_W-1:0]];
    else
      allowed = 1'b1;
    commitNow     = stValid && progEn && allowed;
    strb.wrData   = commitNow && !stSpace;
    strb.wrStatus = commitNow && stSpace && (stRegion != RG_NONE);
    strb.addr     = stAddr;
    strb.wdata    = stData;
  end
endmodule

// File: rtl/apnd_store.sv
`timescale 1ns/1ps
module apnd_store
  import apnd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              space,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        rdData,
  input  logic              progReq,
  input  logic [7:0]        progData,
  input  logic              progEn,
  output logic              progReject,
  input  logic [PG_W-1:0]   lookPage,
  output logic              lookValid,
  output logic [PG_W-1:0]   lookTarget
);
  strobe_t          strb;
  logic [PAGES-1:0] pageOpen;
  logic [PAGES-1:0] redirOpen;

  apnd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .progReq(progReq), .space(space), .addr(addr),
    .progData(progData), .progEn(progEn), .pageOpen(pageOpen),
    .redirOpen(redirOpen), .strb(strb), .progReject(progReject)
  );

  apnd_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .space(space), .addr(addr),
    .rdData(rdData), .pageOpen(pageOpen), .redirOpen(redirOpen),
    .lookPage(lookPage), .lookValid(lookValid), .lookTarget(lookTarget)
  );
endmodule

// File: rtl/apnd_checker.sv
`timescale 1ns/1ps
module apnd_checker
  import apnd_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              space,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        rdData,
  input logic              progReq,
  input logic              progEn,
  input logic              progReject,
  input logic              lookValid,
  input logic [PG_W-1:0]   lookTarget,
  input strobe_t           strb,
  input logic [PAGES-1:0]  pageOpen
);
  // R2: with the read address held, no bit of the read byte may rise
  p_clear_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(addr) && $stable(space)) |-> ((rdData & ~$past(rdData)) == 8'h00));

  // R3: nothing is written unless programming is enabled
  p_commit_needs_en_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrData || strb.wrStatus) |-> progEn);

  // R4: a reject always traces back to a request two edges earlier
  p_reject_has_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    progReject |-> $past(progReq, 2));

  // R5: the datapath never receives a write for a locked page
  p_locked_page_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrData |-> pageOpen[strb.addr[OFF_W +: PG_W]]);

  // R8: the status space above the redirection bytes is a hole
  p_hole_reads_ff_r8: assert property (@(posedge clk) disable iff (!rstN)
    (space && addr >= 11'h140) |-> (rdData == 8'hFF));

  // R9: a current page carries no replacement number
  p_valid_target_r9: assert property (@(posedge clk) disable iff (!rstN)
    lookValid |-> (lookTarget == '0));
endmodule

bind apnd_store apnd_checker u_chk (
  .clk(clk), .rstN(rstN), .space(space), .addr(addr), .rdData(rdData),
  .progReq(progReq), .progEn(progEn), .progReject(progReject),
  .lookValid(lookValid), .lookTarget(lookTarget), .strb(strb),
  .pageOpen(pageOpen)
);

// File: tb/tb_apnd_store.sv
`timescale 1ns/1ps
module tb_apnd_store;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        space = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  rdData;
  logic        progReq = 1'b0;
  logic [7:0]  progData = '0;
  logic        progEn = 1'b0;
  logic        progReject;
  logic [5:0]  lookPage = '0;
  logic        lookValid;
  logic [5:0]  lookTarget;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  apnd_store dut (
    .clk(clk), .rstN(rstN), .space(space), .addr(addr), .rdData(rdData),
    .progReq(progReq), .progData(progData), .progEn(progEn),
    .progReject(progReject), .lookPage(lookPage), .lookValid(lookValid),
    .lookTarget(lookTarget)
  );

  // behavioural reference
  typedef struct { bit sp; int a; int d; } req_t;
  int   dataM [2048];
  int   statM [2048];
  req_t pend [$];
  bit   rejExp = 0;

  function automatic bit implemented(int a);
    return (a <= 'h007) || (a >= 'h020 && a <= 'h027) ||
           (a >= 'h040 && a <= 'h047) || (a >= 'h100 && a <= 'h13F);
  endfunction

  function automatic bit lockBit(int base, int pg);
    return ((statM[base + pg / 8] >> (pg % 8)) & 1) != 0;
  endfunction

  task automatic modelEdge();
    rejExp = 0;
    if (pend.size() > 0) begin
      req_t r = pend.pop_front();
      if (!progEn) rejExp = 1;
      else if (!r.sp) begin
        if (!lockBit('h000, r.a / 32)) rejExp = 1;
        else dataM[r.a] = dataM[r.a] & r.d;
      end else if (implemented(r.a)) begin
        if (r.a >= 'h100 && !lockBit('h020, r.a - 'h100)) rejExp = 1;
        else statM[r.a] = statM[r.a] & r.d;
      end
    end
    if (progReq) begin
      req_t n;
      n.sp = space; n.a = int'(addr); n.d = int'(progData);
      pend.push_back(n);
    end
  endtask

  task automatic check(string tag, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  task automatic step(string tag);
    int expRd, rb;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    expRd = space ? (implemented(int'(addr)) ? statM[int'(addr)] : 'hFF) : dataM[int'(addr)];
    rb = statM['h100 + int'(lookPage)];
    check(tag, "rdData", int'(rdData), expRd);
    check(tag, "progReject", int'(progReject), int'(rejExp));
    check(tag, "lookValid", int'(lookValid), int'(rb == 'hFF));
    check(tag, "lookTarget", int'(lookTarget), (~rb) & 'h3F);
  endtask

  task automatic prog(bit sp, int a, int d, bit en, string tag);
    space = sp; addr = 11'(a); progData = 8'(d); progReq = 1'b1; progEn = en;
    step(tag);
    progReq = 1'b0;
    step(tag);
    step(tag);
  endtask

  task automatic rd(bit sp, int a, string tag);
    space = sp; addr = 11'(a); progReq = 1'b0;
    step(tag);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) begin dataM[i] = 'hFF; statM[i] = 'hFF; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: erased state everywhere
    rd(0, 'h000, "R1"); rd(0, 'h7FF, "R1"); rd(1, 'h000, "R1");
    rd(1, 'h13F, "R1"); rd(1, 'h047, "R1"); lookPage = 6'd63; rd(1, 'h027, "R1");
    lookPage = 6'd1;
    // R2 / R3: successive programs AND together, visible after commit
    prog(0, 'h045, 'hF3, 1, "R3");
    prog(0, 'h045, 'h3C, 1, "R2");
    prog(0, 'h045, 'hFF, 1, "R2");
    // R4: no enable, no change, one-cycle reject
    prog(0, 'h046, 'h00, 0, "R4");
    rd(0, 'h046, "R4");
    // R5: lock page 1, then try to program inside it
    prog(1, 'h000, 'hFD, 1, "R5");
    prog(0, 'h025, 'h00, 1, "R5");
    rd(0, 'h025, "R5");
    prog(0, 'h010, 'h0F, 1, "R5");
    prog(0, 'h120, 'h55, 1, "R5");
    // R9: redirect page 1 to page 2
    prog(1, 'h101, 'hFD, 1, "R9");
    lookPage = 6'd2; rd(1, 'h101, "R9");
    lookPage = 6'd1; rd(1, 'h102, "R9");
    // R6: lock the redirection byte of page 1
    prog(1, 'h020, 'hFD, 1, "R6");
    prog(1, 'h101, 'h00, 1, "R6");
    prog(1, 'h102, 'hF0, 1, "R6");
    // R7: used map has no effect on permissions
    prog(1, 'h040, 'h00, 1, "R7");
    prog(0, 'h003, 'h77, 1, "R7");
    prog(1, 'h100, 'hFE, 1, "R7");
    // R8: holes read FF and swallow writes silently
    rd(1, 'h010, "R8"); rd(1, 'h030, "R8"); rd(1, 'h080, "R8");
    rd(1, 'h200, "R8"); rd(1, 'h7FF, "R8");
    prog(1, 'h010, 'h00, 1, "R8");
    prog(1, 'h150, 'h00, 1, "R8");
    // R10: lock page 2 and hit it on the next cycle
    space = 1; addr = 11'h000; progData = 8'hFB; progReq = 1; progEn = 1;
    step("R10");
    space = 0; addr = 11'h045; progData = 8'h00;
    step("R10");
    progReq = 0;
    step("R10"); step("R10");
    // R2: mixed random traffic
    for (int i = 0; i < 400; i++) begin
      int pick = int'($urandom % 10);
      int sa;
      case (pick)
        0: sa = 'h000; 1: sa = 'h001; 2: sa = 'h020; 3: sa = 'h100;
        4: sa = 'h101; 5: sa = 'h104; 6: sa = 'h041; 7: sa = 'h018;
        8: sa = 'h022; default: sa = 'h13F;
      endcase
      lookPage = 6'($urandom % 6);
      space = 1'($urandom % 2);
      addr = space ? 11'(sa) : 11'($urandom % 256);
      progData = 8'($urandom | $urandom);
      progReq = 1'($urandom % 2);
      progEn = ($urandom % 4) != 0;
      step("R2");
    end
    progReq = 0;
    step("R2"); step("R2");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R3 watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule